// File: doc/BRIEF.md
# Saturating Tiled Approximate Multiplier

This block multiplies two unsigned 8-bit operands into a 16-bit product. The work is split across eight small tiles. Each tile multiplies one 4-bit digit of the first operand by one 2-bit digit of the second. An exact tile returns its full 6-bit product. An approximate tile keeps only 5 bits and clamps any product of 32 or more to 31. Power- or area-sensitive datapaths that can absorb a small, bounded error use it to trade accuracy for logic.

A parameter sets how many tiles use the approximate form. Tiles are converted in order of ascending weight, so the error stays in the low-order part of the result. The tile outputs are registered. They are then summed with a packed adder arrangement: tiles whose bit spans do not overlap share one addend row, and each adder covers only the columns that can hold ones. The two stages form a pipeline that accepts one operand pair per cycle. A valid flag travels alongside the data.

Top module: `tile_approx_mult`

## Requirements
- R1: An exact tile contributes the full product of its 4-bit digit and 2-bit digit (0 to 45), with no loss of bits.
- R2: An approximate tile contributes min(digit product, 31). With a 4-bit digit of 15 and a 2-bit digit of 3, it contributes 31 instead of 45.
- R3: Tile (a, b) pairs bits [4a+3:4a] of opA with bits [2b+1:2b] of opB, and its weight is 2^(4a+2b). Tiles are ranked by ascending weight, and a tie goes to the lower opA digit index. The NUM_APPROX lowest-ranked tiles are approximate. With NUM_APPROX = 3, tile (0,2) is approximate and tile (1,0) is exact, although both carry weight 16.
- R4: product equals the sum, modulo 2^16, of every tile contribution multiplied by its weight.
- R5: outValid rises exactly two rising clock edges after the edge that sampled inValid high. product carries the result for that input in the same cycle.
- R6: While outValid is low, product holds its last value.
- R7: A synchronous reset (rst high at a rising edge) clears outValid and product to zero. Inputs presented during reset produce no result.
- R8: Operand pairs presented on consecutive cycles produce results on consecutive cycles, with no bubbles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operand pair on opA/opB is valid this cycle |
| opA | input | 8 | Unsigned operand split into 4-bit digits |
| opB | input | 8 | Unsigned operand split into 2-bit digits |
| outValid | output | 1 | product holds a new result |
| product | output | 16 | Approximate unsigned product |

## Verification
Each result is due on the second rising edge after its operands are sampled. That is the tile register followed by the sum register. The driver stamps every expected item with its issue cycle. The monitor samples on the falling edge and requires a gap of exactly two cycles. During the back-to-back sweep, the monitor also requires each result to arrive one cycle after the previous one. In idle cycles and right after reset, the monitor checks that product has not moved.

// File: rtl/tam_pkg.sv
package tam_pkg;
  parameter int OP_W    = 8;
  parameter int A_DIG_W = 4;
  parameter int B_DIG_W = 2;

  localparam int A_DIGITS   = OP_W / A_DIG_W;
  localparam int B_DIGITS   = OP_W / B_DIG_W;
  localparam int TILES      = A_DIGITS * B_DIGITS;
  localparam int TILE_W     = A_DIG_W + B_DIG_W;
  localparam int PROD_W     = 2 * OP_W;
  localparam int APPROX_MAX = (1 << (TILE_W - 1)) - 1;

  typedef logic [TILE_W-1:0] tile_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // load tile register
    logic sum;      // load result register
  } stage_strobe_t;

  function automatic int tileShift(input int a, input int b);
    return a * A_DIG_W + b * B_DIG_W;
  endfunction

  // rank by weight, ties broken toward lower opA digit
  function automatic int tileRank(input int a, input int b);
    int r;
    r = 0;
    for (int i = 0; i < A_DIGITS; i++) begin
      for (int j = 0; j < B_DIGITS; j++) begin
        if ((tileShift(i, j) < tileShift(a, b)) ||
            ((tileShift(i, j) == tileShift(a, b)) && (i < a)))
          r++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/tam_tile.sv
module tam_tile
  import tam_pkg::*;
#(
  parameter bit APPROX = 1'b0
) (
  input  logic [A_DIG_W-1:0] digitA,
  input  logic [B_DIG_W-1:0] digitB,
  output tile_t              tileProd
);
  tile_t fullProd;

  always_comb fullProd = TILE_W'(digitA) * TILE_W'(digitB);

  generate
    if (APPROX) begin : g_clamp
      always_comb tileProd = (fullProd > tile_t'(APPROX_MAX)) ? tile_t'(APPROX_MAX) : fullProd;
    end else begin : g_exact
      always_comb tileProd = fullProd;
    end
  endgenerate
endmodule

// File: rtl/tam_ctrl.sv
module tam_ctrl
  import tam_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output stage_strobe_t strobe,
  output logic          outValid
);
  logic validS1;
  logic validS2;

  always_ff @(posedge clk) begin
    if (rst) begin
      validS1 <= 1'b0;
      validS2 <= 1'b0;
    end else begin
      validS1 <= inValid;
      validS2 <= validS1;
    end
  end

  always_comb begin
    strobe.capture = inValid;
    strobe.sum     = validS1;
    outValid       = validS2;
  end

  AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 2)); // R5

  AST_RESET_VALID: assert property (@(posedge clk)
    rst |=> !outValid); // R7
endmodule

// File: rtl/tam_datapath.sv
module tam_datapath
  import tam_pkg::*;
#(
  parameter int NUM_APPROX = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  stage_strobe_t     strobe,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [PROD_W-1:0] product
);
  tile_t [TILES-1:0] tileOut;
  tile_t [TILES-1:0] tileReg;

  generate
    for (genvar a = 0; a < A_DIGITS; a++) begin : g_adig
      for (genvar b = 0; b < B_DIGITS; b++) begin : g_bdig
        localparam int IDX = a * B_DIGITS + b;
        localparam bit IS_APPROX = (tileRank(a, b) < NUM_APPROX);
        tam_tile #(.APPROX(IS_APPROX)) u_tile (
          .digitA  (opA[a*A_DIG_W +: A_DIG_W]),
          .digitB  (opB[b*B_DIG_W +: B_DIG_W]),
          .tileProd(tileOut[IDX])
        );
        if (IS_APPROX) begin : g_chk
          AST_APPROX_CLAMP: assert property (@(posedge clk) disable iff (rst)
            strobe.capture |=> (tileReg[IDX] <= tile_t'(APPROX_MAX))); // R2
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) tileReg <= '0;
    else if (strobe.capture) tileReg <= tileOut;
  end

  // packed rows: non-overlapping tiles share a row
  // tile index = a*4+b, weight shift = 4a+2b
  logic [11:0] rowA;  // columns 11..0  : tile(1,1) | tile(0,0)
  logic [11:0] rowB;  // columns 13..2  : tile(1,2) | tile(0,1)
  logic [11:0] rowC;  // columns 15..4  : tile(1,3) | tile(0,2)
  logic [5:0]  rowD;  // columns 9..4   : tile(1,0)
  logic [5:0]  rowE;  // columns 11..6  : tile(0,3)
  logic [12:0] sumAB;   // weight 2^2
  logic [8:0]  sumDE;   // weight 2^4
  logic [11:0] sumCDE;  // weight 2^4
  logic [13:0] sumHigh; // weight 2^2
  logic [PROD_W-1:0] productNext;

  always_comb begin
    rowA = {tileReg[5], tileReg[0]};
    rowB = {tileReg[6], tileReg[1]};
    rowC = {tileReg[7], tileReg[2]};
    rowD = tileReg[4];
    rowE = tileReg[3];
    sumAB   = {3'b000, rowA[11:2]} + {1'b0, rowB};
    sumDE   = {1'b0, rowE, 2'b00} + {3'b000, rowD};
    sumCDE  = rowC + {3'b000, sumDE};
    sumHigh = {1'b0, sumAB} + {sumCDE, 2'b00};
    productNext = {sumHigh, rowA[1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) product <= '0;
    else if (strobe.sum) product <= productNext;
  end

  // plain zero-extend-and-add of the tile register
  function automatic logic [PROD_W-1:0] plainSum(input tile_t [TILES-1:0] t);
    logic [PROD_W-1:0] acc;
    acc = '0;
    for (int a = 0; a < A_DIGITS; a++)
      for (int b = 0; b < B_DIGITS; b++)
        acc = acc + (PROD_W'(t[a*B_DIGITS+b]) << tileShift(a, b));
    return acc;
  endfunction

  AST_PACKED_SUM: assert property (@(posedge clk) disable iff (rst)
    strobe.sum |=> (product == plainSum($past(tileReg)))); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !strobe.sum |=> $stable(product)); // R6

  AST_RESET_PRODUCT: assert property (@(posedge clk)
    rst |=> (product == '0)); // R7
endmodule

// File: rtl/tile_approx_mult.sv
module tile_approx_mult
  import tam_pkg::*;
#(
  parameter int NUM_APPROX = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic              outValid,
  output logic [PROD_W-1:0] product
);
  stage_strobe_t strobe;

  tam_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  tam_datapath #(.NUM_APPROX(NUM_APPROX)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .product(product)
  );
endmodule

// File: tb/tile_approx_mult_bench.sv
module tile_approx_mult_bench;
  localparam int NAPX = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic outValid;
  logic [15:0] product;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [15:0] expQ[$];
  int issueQ[$];
  string tagQ[$];
  logic [15:0] lastProd = '0;
  int lastOutCyc = -10;
  string lastTag = "";

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  tile_approx_mult #(.NUM_APPROX(NAPX)) u_tile_approx_mult (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .product(product)
  );

  // expected value from the requirement text
  function automatic logic [15:0] refProd(input logic [7:0] a, input logic [7:0] b);
    int sum;
    sum = 0;
    for (int i = 0; i < 2; i++) begin
      for (int j = 0; j < 4; j++) begin
        int sh, rank, p;
        sh = 4 * i + 2 * j;
        rank = 0;
        for (int i2 = 0; i2 < 2; i2++)
          for (int j2 = 0; j2 < 4; j2++)
            if ((4*i2 + 2*j2 < sh) || ((4*i2 + 2*j2 == sh) && (i2 < i))) rank++;
        p = int'((a >> (4*i)) & 8'hF) * int'((b >> (2*j)) & 8'h3);
        if (rank < NAPX && p > 31) p = 31;
        sum += p << sh;
      end
    end
    return sum[15:0];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] a, input logic [7:0] b, input string tag);
    @(negedge clk);
    opA = a; opB = b; inValid = 1'b1;
    expQ.push_back(refProd(a, b));
    issueQ.push_back(cyc);
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5 unexpected result", int'(product), 0);
        end else begin
          logic [15:0] e;
          int iss;
          string t;
          e = expQ.pop_front();
          iss = issueQ.pop_front();
          t = tagQ.pop_front();
          check(product == e, t, int'(product), int'(e));
          check(cyc - iss == 2, "R5 latency", cyc - iss, 2);
          if (t == "R4" && lastTag == "R4")
            check(cyc == lastOutCyc + 1, "R8 back-to-back", cyc - lastOutCyc, 1);
          lastTag = t;
          lastOutCyc = cyc;
          lastProd = product;
        end
      end else begin
        check(product == lastProd, "R6 hold while idle", int'(product), int'(lastProd));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // inputs during reset must be dropped (R7)
    rst = 1'b1; inValid = 1'b1; opA = 8'hFF; opB = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0; inValid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(outValid == 1'b0, "R7 outValid after reset", int'(outValid), 0);
      check(product == 16'h0, "R7 product after reset", int'(product), 0);
      @(negedge clk);
    end

    // R1: tile (1,3) exact, 15*3 at weight 2^10
    drive(8'hF0, 8'hC0, "R1");
    idle(3);
    check(refProd(8'hF0, 8'hC0) == 16'd46080, "R1 model", int'(refProd(8'hF0, 8'hC0)), 46080);
    // R2: tile (0,0) clamps 45 to 31
    drive(8'h0F, 8'h03, "R2");
    idle(2);
    check(refProd(8'h0F, 8'h03) == 16'd31, "R2 model", int'(refProd(8'h0F, 8'h03)), 31);
    drive(8'hFF, 8'hFF, "R2");
    // R3: equal weight 16, tile (0,2) approx, tile (1,0) exact
    drive(8'h0F, 8'h30, "R3");
    drive(8'hF0, 8'h03, "R3");
    idle(4);
    check(refProd(8'h0F, 8'h30) == 16'd496, "R3 model low", int'(refProd(8'h0F, 8'h30)), 496);
    check(refProd(8'hF0, 8'h03) == 16'd720, "R3 model high", int'(refProd(8'hF0, 8'h03)), 720);
    drive(8'h00, 8'hAB, "R4");
    idle(5);

    // exhaustive back-to-back sweep
    lastTag = "";
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        drive(a[7:0], b[7:0], "R4");
    idle(6);
    check(expQ.size() == 0, "R8 all results delivered", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule